// File: doc/BRIEF.md
# Pulse Width Demodulator Front End

This block measures how long a cleaned-up digital input stays high and how long it stays low. The input first passes through a two-flop synchronizer. When measurement mode is on, the synchronized level runs one phase counter and one request line directly. Its inverse runs a second phase counter and a second request line. Software reads the width of the last completed high phase from one register and the width of the last completed low phase from another. It finds the pulse width or duty cycle by comparing the two.

Each phase counter counts clock cycles while its phase lasts. When the phase ends, the count is moved into the matching width register, the counter restarts from zero, and a sticky interrupt flag is raised. A counter stops at its largest value rather than wrapping. When that happens, an overflow status bit is captured together with the width. The synchronized level also appears as the top bit of a general-purpose read word. When the mode is off, the counter gates and the low-phase request come from dedicated pins, and the measurement logic stands still.

Top module: `pwm_demod_front`

## Requirements
- R1: While rst_n is low, hi_width, lo_width, hi_ovf, lo_ovf, hi_irq and lo_irq are all zero.
- R2: sig_in is seen through a two-flop synchronizer. A change on sig_in reaches the level outputs after the second rising clock edge.
- R3: With enable=1, t0_gate and req_hi_line equal the synchronized level, and t1_gate and req_lo_line equal its inverse.
- R4: With enable=1, the pins alt_cnt0_pin, alt_cnt1_pin and alt_req_lo_pin have no effect on any output.
- R5: With enable=0, t0_gate follows alt_cnt0_pin, t1_gate follows alt_cnt1_pin and req_lo_line follows alt_req_lo_pin. req_hi_line still follows the synchronized level.
- R6: gpio_rd[31] is the synchronized level and gpio_rd[30:0] equals gpio_in.
- R7: After sig_in has been high for H clock cycles and then falls, hi_width becomes H when the synchronized falling edge is seen.
- R8: After sig_in has been low for L clock cycles and then rises, lo_width becomes L when the synchronized rising edge is seen.
- R9: hi_irq is set on each captured falling edge and lo_irq on each captured rising edge. The flags stay set until ack_hi or ack_lo is high at a clock edge. If a set and an ack fall in the same cycle, the set wins.
- R10: A phase counter saturates at 2^CW-1. If a phase outlasts the counter, the captured width is 2^CW-1 and the matching overflow bit (hi_ovf or lo_ovf) is 1. A capture without saturation clears that bit.
- R11: With enable=0, both counters hold their values, the width and overflow registers do not change, and no flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Measurement mode on |
| sig_in | input | 1 | Asynchronous cleaned input signal |
| alt_cnt0_pin | input | 1 | Dedicated count input for timer 0, used when the mode is off |
| alt_cnt1_pin | input | 1 | Dedicated count input for timer 1, used when the mode is off |
| alt_req_lo_pin | input | 1 | Dedicated request input for the low-phase line, used when the mode is off |
| gpio_in | input | 31 | Other general-purpose levels for the read word |
| ack_hi | input | 1 | Clears hi_irq |
| ack_lo | input | 1 | Clears lo_irq |
| t0_gate | output | 1 | Count enable routed to timer 0 |
| t1_gate | output | 1 | Count enable routed to timer 1 |
| req_hi_line | output | 1 | High-phase request line |
| req_lo_line | output | 1 | Low-phase request line |
| hi_width | output | CW | Last captured high-phase width |
| lo_width | output | CW | Last captured low-phase width |
| hi_ovf | output | 1 | Last high phase saturated |
| lo_ovf | output | 1 | Last low phase saturated |
| hi_irq | output | 1 | High phase ended |
| lo_irq | output | 1 | Low phase ended |
| gpio_rd | output | 32 | Read word with the level in bit 31 |

## Verification
A software acknowledge of a flag can reach the block in the same cycle as the next edge capture that sets that flag. The bench lowers the input and counts the two synchronizer edges. It then holds ack_hi high across exactly the capture edge and expects hi_irq to be set afterwards. A separate ack with no edge nearby must clear the flag, so the test can tell that the capture won the collision.

// File: rtl/pwm_demod_front.sv
module pwm_demod_front #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          sig_in,
  input  logic          alt_cnt0_pin,
  input  logic          alt_cnt1_pin,
  input  logic          alt_req_lo_pin,
  input  logic [30:0]   gpio_in,
  input  logic          ack_hi,
  input  logic          ack_lo,
  output logic          t0_gate,
  output logic          t1_gate,
  output logic          req_hi_line,
  output logic          req_lo_line,
  output logic [CW-1:0] hi_width,
  output logic [CW-1:0] lo_width,
  output logic          hi_ovf,
  output logic          lo_ovf,
  output logic          hi_irq,
  output logic          lo_irq,
  output logic [31:0]   gpio_rd
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic s1, lvl, lvl_d;
  logic [CW-1:0] hi_cnt, lo_cnt;
  logic hi_sat, lo_sat;

  wire fall = enable & lvl_d & ~lvl;
  wire rise = enable & ~lvl_d & lvl;

  assign t0_gate     = enable ? lvl  : alt_cnt0_pin;
  assign t1_gate     = enable ? ~lvl : alt_cnt1_pin;
  assign req_hi_line = lvl;
  assign req_lo_line = enable ? ~lvl : alt_req_lo_pin;
  assign gpio_rd     = {lvl, gpio_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0; lvl <= 1'b0; lvl_d <= 1'b0;
    end else begin
      s1 <= sig_in; lvl <= s1; lvl_d <= lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= '0; hi_sat <= 1'b0; hi_width <= '0; hi_ovf <= 1'b0;
    end else if (enable) begin
      if (fall) begin
        hi_width <= hi_cnt;
        hi_ovf   <= hi_sat;
        hi_cnt   <= '0;
        hi_sat   <= 1'b0;
      end else if (lvl) begin
        if (hi_cnt == CMAX) hi_sat <= 1'b1;
        else                hi_cnt <= hi_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_cnt <= '0; lo_sat <= 1'b0; lo_width <= '0; lo_ovf <= 1'b0;
    end else if (enable) begin
      if (rise) begin
        lo_width <= lo_cnt;
        lo_ovf   <= lo_sat;
        lo_cnt   <= '0;
        lo_sat   <= 1'b0;
      end else if (!lvl) begin
        if (lo_cnt == CMAX) lo_sat <= 1'b1;
        else                lo_cnt <= lo_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_irq <= 1'b0; lo_irq <= 1'b0;
    end else begin
      hi_irq <= fall | (hi_irq & ~ack_hi);
      lo_irq <= rise | (lo_irq & ~ack_lo);
    end
  end

  assert_gates_split_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> (t0_gate != t1_gate) && (req_hi_line != req_lo_line));

  assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl) |-> $past(s1));

  assert_hi_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> hi_width == $past(hi_cnt) && hi_cnt == '0);

  assert_lo_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> lo_width == $past(lo_cnt) && lo_cnt == '0);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && ack_hi) |=> hi_irq);

  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && lvl && !fall && hi_cnt == CMAX) |=> hi_cnt == CMAX);

  assert_hold_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(hi_cnt) && $stable(lo_cnt) && $stable(hi_width) && $stable(lo_width));

  assert_no_flag_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hi_irq) || $rose(lo_irq)) |-> $past(enable));
endmodule

// File: tb/pwm_demod_front_tb.sv
module pwm_demod_front_tb;
  localparam int CW = 8;
  localparam int NV = 6;
  localparam int VEC [NV][2] = '{'{5, 7}, '{3, 3}, '{12, 4}, '{40, 9}, '{4, 25}, '{100, 3}};

  logic clk = 0, rst_n = 0, enable = 0, sig_in = 0;
  logic alt_cnt0_pin = 0, alt_cnt1_pin = 0, alt_req_lo_pin = 0, ack_hi = 0, ack_lo = 0;
  logic [30:0] gpio_in = '0;
  logic t0_gate, t1_gate, req_hi_line, req_lo_line, hi_ovf, lo_ovf, hi_irq, lo_irq;
  logic [CW-1:0] hi_width, lo_width;
  logic [31:0] gpio_rd;
  int total = 0, bad = 0;
  logic [CW-1:0] keep_hi, keep_lo;

  always #4 clk = ~clk;

  pwm_demod_front #(.CW(CW)) u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R1 hi_width", hi_width, 0);
    chk("R1 lo_width", lo_width, 0);
    chk("R1 flags", {hi_irq, lo_irq, hi_ovf, lo_ovf}, 0);
    rst_n = 1; enable = 1;
    cyc(4);
    for (int i = 0; i < NV; i++) begin
      sig_in = 1;
      cyc(VEC[i][0]);
      if (i > 0) chk("R8 lo_width", lo_width, VEC[i-1][1]);
      chk("R3 gates high", {t0_gate, t1_gate, req_hi_line, req_lo_line}, 4'b1010);
      chk("R6 level bit", gpio_rd[31], 1);
      sig_in = 0;
      cyc(VEC[i][1]);
      chk("R7 hi_width", hi_width, VEC[i][0]);
      chk("R7 hi_irq set R9", hi_irq, 1);
      chk("R3 gates low", {t0_gate, t1_gate, req_hi_line, req_lo_line}, 4'b0101);
    end
    sig_in = 1;
    cyc(4);
    chk("R8 last lo_width", lo_width, VEC[NV-1][1]);
    chk("R9 lo_irq", lo_irq, 1);

    // R2: the level shows after the second edge
    sig_in = 0; cyc(1);
    chk("R2 one edge", gpio_rd[31], 1);
    cyc(1);
    chk("R2 two edges", gpio_rd[31], 0);
    sig_in = 1; cyc(4);

    // R4: dedicated pins ignored in mode
    alt_cnt0_pin = 0; alt_cnt1_pin = 1; alt_req_lo_pin = 1;
    cyc(2);
    chk("R4 pins ignored", {t0_gate, t1_gate, req_hi_line, req_lo_line}, 4'b1010);
    alt_cnt0_pin = 0; alt_cnt1_pin = 0; alt_req_lo_pin = 0;

    // R9: plain ack clears, other flag untouched
    ack_hi = 1; cyc(1); ack_hi = 0;
    chk("R9 ack clears hi", hi_irq, 0);
    chk("R9 lo kept", lo_irq, 1);
    ack_lo = 1; cyc(1); ack_lo = 0;
    chk("R9 ack clears lo", lo_irq, 0);

    // R9: ack collides with capture edge
    sig_in = 0; cyc(2);
    ack_hi = 1; cyc(1); ack_hi = 0;
    chk("R9 set wins over ack", hi_irq, 1);
    cyc(4);

    // R10: saturation of both phases
    sig_in = 1; cyc(300);
    sig_in = 0; cyc(5);
    chk("R10 hi saturates", hi_width, 255);
    chk("R10 hi_ovf", hi_ovf, 1);
    sig_in = 1; cyc(6);
    sig_in = 0; cyc(270);
    chk("R10 hi normal", hi_width, 6);
    chk("R10 hi_ovf cleared", hi_ovf, 0);
    sig_in = 1; cyc(5);
    chk("R10 lo saturates", lo_width, 255);
    chk("R10 lo_ovf", lo_ovf, 1);
    sig_in = 0; cyc(5);
    sig_in = 1; cyc(5);
    chk("R10 lo normal", lo_width, 5);
    chk("R10 lo_ovf cleared", lo_ovf, 0);

    // R11 and R5: mode off
    ack_hi = 1; ack_lo = 1; cyc(1); ack_hi = 0; ack_lo = 0;
    enable = 0;
    keep_hi = hi_width; keep_lo = lo_width;
    sig_in = 0; cyc(10);
    sig_in = 1; cyc(10);
    sig_in = 0; cyc(10);
    chk("R11 hi_width held", hi_width, keep_hi);
    chk("R11 lo_width held", lo_width, keep_lo);
    chk("R11 no flags", {hi_irq, lo_irq}, 0);
    alt_cnt0_pin = 1; alt_cnt1_pin = 0; alt_req_lo_pin = 1;
    cyc(1);
    chk("R5 pins routed a", {t0_gate, t1_gate, req_hi_line, req_lo_line}, 4'b1001);
    alt_cnt0_pin = 0; alt_cnt1_pin = 1; alt_req_lo_pin = 0;
    cyc(1);
    chk("R5 pins routed b", {t0_gate, t1_gate, req_hi_line, req_lo_line}, 4'b0100);

    // R6: pass-through bits
    gpio_in = 31'h2AC3_5F19; cyc(1);
    chk("R6 gpio low bits", gpio_rd, {1'b0, 31'h2AC3_5F19});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule